// File: doc/BRIEF.md
# Transactional Read-Set Abort Tracker

This block follows the read-set of a single hardware transaction whose footprint lives in a private cache of fixed size. A transaction is opened with a begin strobe. While it is open, every read presents a line address, and the tracker records each new line in a small associative store. Invalidations and evictions also present a line address. If either one removes a line that the transaction has already read, the transaction is doomed. The tracker raises a one-cycle abort pulse with a conflict cause, clears the store and returns to idle. A commit closes the transaction normally, pulses a commit acknowledge and also clears the store.

The tracker does not know why a line disappeared. A remote writer's invalidation and a back-invalidation caused by the transaction's own pressure on an inclusive shared cache look the same at its inputs, so both abort as conflicts. There is a separate capacity limit. If a read of a new line arrives when the store is already full, the transaction aborts with an overflow cause. Write buffering, data versioning and retry policy belong to surrounding logic.

Top module: `rdset_abort_tracker`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, tx_active, abort_pulse and commit_ok are 0 and abort_cause is 2'b00. Reset taken during an open transaction closes it.
- R2: When idle, tx_begin sets tx_active from the next cycle. A tx_begin while a transaction is open has no effect.
- R3: While active, a read of a line not yet recorded takes one entry. A read of a recorded line takes none, so RS_DEPTH distinct lines, each re-read any number of times, fit without abort.
- R4: An invalidation whose address matches a recorded line gives, one cycle later, abort_pulse=1 with abort_cause=2'b01 (conflict) and tx_active=0. This applies to every entry position, including the last one filled.
- R5: An eviction whose address matches a recorded line aborts in the same way as R4, with the same conflict cause.
- R6: An invalidation or eviction to an unrecorded address, or one arriving while idle, causes no abort. A later commit still succeeds.
- R7: A read of a new line while RS_DEPTH lines are held gives, one cycle later, abort_pulse=1 with abort_cause=2'b10 (overflow) and tx_active=0.
- R8: tx_commit while active gives a one-cycle commit_ok pulse and tx_active=0 in the next cycle. The read-set is emptied, so a later transaction is not aborted by lines read earlier.
- R9: A conflict on the same cycle as a commit or an overflowing read resolves as a conflict abort (cause 2'b01), with commit_ok=0.
- R10: abort_pulse lasts one cycle. abort_cause is 2'b00 whenever abort_pulse is 0. The read-set is empty after any abort.
- R11: Reads presented while idle, including on the cycle of tx_begin, are not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_begin | input | 1 | Open a transaction |
| tx_commit | input | 1 | Close the open transaction successfully |
| rd_valid | input | 1 | A transactional read occurs this cycle |
| rd_addr | input | ADDR_W | Line address of the read |
| inv_valid | input | 1 | A line is invalidated in the private cache |
| inv_addr | input | ADDR_W | Line address of the invalidation |
| evict_valid | input | 1 | A line is evicted from the private cache |
| evict_addr | input | ADDR_W | Line address of the eviction |
| tx_active | output | 1 | A transaction is open |
| abort_pulse | output | 1 | One-cycle abort indication, registered |
| abort_cause | output | 2 | 2'b01 conflict, 2'b10 overflow, 2'b00 otherwise |
| commit_ok | output | 1 | One-cycle successful-commit indication, registered |

## Verification
The bench fills the read-set to exactly its depth while repeatedly re-reading lines. A design that allocated on duplicates would report overflow early, and one with an off-by-one limit would abort on the sixteenth line or let a seventeenth through. It invalidates the last entry filled, to catch matching logic that skips the top slot. It also lines a conflict up on the same cycle as a commit and as an overflowing read, where a wrong priority shows as a commit acknowledge or an overflow cause. Stale lines are probed after commit and after abort, and reads on the begin cycle are checked, because a tracker that forgot to clear, or that recorded while idle, would raise an abort for a line the new transaction never touched.

// File: rtl/rdset_pkg.sv
// Package: shared types for the read-set abort tracker.
// Assumes: abort cause codes are visible at the top-level port as 2 bits.
package rdset_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'b00,
        CAUSE_CONFLICT = 2'b01,
        CAUSE_OVERFLOW = 2'b10
    } abort_cause_e;

endpackage

// File: rtl/rdset_cam.sv
// Module: rdset_cam
// Small associative store holding the line addresses of the open read-set.
// Entries fill in order from index 0 and are only ever emptied all at once,
// so the fill count doubles as the next free index.
// Assumes: alloc and clear are never high together; alloc is never high when full.
module rdset_cam #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic              clear,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic [ADDR_W-1:0] ev_addr,
    output logic              rd_hit,
    output logic              inv_hit,
    output logic              ev_hit,
    output logic              full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  fill_cnt;
    logic [DEPTH-1:0]  ent_vld;
    logic [ADDR_W-1:0] ent_addr [DEPTH];
    logic [DEPTH-1:0]  rd_match, inv_match, ev_match;

    // Track how many entries are in use.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            fill_cnt <= '0;
        else if (alloc)
            fill_cnt <= fill_cnt + CNT_W'(1);
    end

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_ent
            // Capture a new line into slot k when it is the next free one.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    ent_vld[k]  <= 1'b0;
                    ent_addr[k] <= '0;
                end else if (alloc && fill_cnt == CNT_W'(k)) begin
                    ent_vld[k]  <= 1'b1;
                    ent_addr[k] <= rd_addr;
                end
            end

            // Compare slot k against the three lookup addresses.
            always_comb begin
                rd_match[k]  = ent_vld[k] && (ent_addr[k] == rd_addr);
                inv_match[k] = ent_vld[k] && (ent_addr[k] == inv_addr);
                ev_match[k]  = ent_vld[k] && (ent_addr[k] == ev_addr);
            end
        end
    endgenerate

    // Reduce the per-slot matches into hit flags.
    always_comb begin
        rd_hit  = |rd_match;
        inv_hit = |inv_match;
        ev_hit  = |ev_match;
        full    = (fill_cnt == CNT_W'(DEPTH));
    end

endmodule

// File: rtl/rdset_ctrl.sv
// Module: rdset_ctrl
// Transaction state and abort/commit decisions. Priority inside an open
// transaction: conflict (loss of a recorded line), then overflow, then commit,
// then allocation of a new line. Outputs are registered one-cycle pulses.
// Assumes: hit flags reflect the read-set as it stood before this cycle.
module rdset_ctrl
    import rdset_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_begin,
    input  logic         tx_commit,
    input  logic         rd_valid,
    input  logic         inv_valid,
    input  logic         ev_valid,
    input  logic         rd_hit,
    input  logic         inv_hit,
    input  logic         ev_hit,
    input  logic         full,
    output logic         active,
    output logic         alloc,
    output logic         clear,
    output logic         abort_pulse,
    output abort_cause_e abort_cause,
    output logic         commit_ok
);
    logic conflict, overflow, do_commit, new_line;

    // Classify what this cycle does to the open transaction.
    always_comb begin
        new_line  = rd_valid && !rd_hit;
        conflict  = active && ((inv_valid && inv_hit) || (ev_valid && ev_hit));
        overflow  = active && !conflict && new_line && full;
        do_commit = active && !conflict && !overflow && tx_commit;
        alloc     = active && !conflict && !tx_commit && new_line && !full;
        clear     = conflict || overflow || do_commit;
    end

    // Hold the transaction-open state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (!active)
            active <= tx_begin;
        else if (clear)
            active <= 1'b0;
    end

    // Register the abort and commit pulses with their cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_pulse <= 1'b0;
            abort_cause <= CAUSE_NONE;
            commit_ok   <= 1'b0;
        end else begin
            abort_pulse <= conflict || overflow;
            abort_cause <= conflict ? CAUSE_CONFLICT :
                           overflow ? CAUSE_OVERFLOW : CAUSE_NONE;
            commit_ok   <= do_commit;
        end
    end

endmodule

// File: rtl/rdset_abort_tracker.sv
// Module: rdset_abort_tracker (top)
// Tracks the read-set of one hardware transaction. Any loss of a recorded
// line aborts as a conflict regardless of its reason; a read beyond the
// store's capacity aborts as an overflow.
// Assumes: one read, one invalidation and one eviction at most per cycle.
module rdset_abort_tracker #(
    parameter int RS_DEPTH = 16,
    parameter int ADDR_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_begin,
    input  logic              tx_commit,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    output logic              tx_active,
    output logic              abort_pulse,
    output logic [1:0]        abort_cause,
    output logic              commit_ok
);
    import rdset_pkg::*;

    logic         rs_alloc, rs_clear, rs_full;
    logic         hit_rd, hit_inv, hit_ev;
    abort_cause_e cause_q;

    rdset_cam #(.DEPTH(RS_DEPTH), .ADDR_W(ADDR_W)) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc    (rs_alloc),
        .clear    (rs_clear),
        .rd_addr  (rd_addr),
        .inv_addr (inv_addr),
        .ev_addr  (evict_addr),
        .rd_hit   (hit_rd),
        .inv_hit  (hit_inv),
        .ev_hit   (hit_ev),
        .full     (rs_full)
    );

    rdset_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_begin    (tx_begin),
        .tx_commit   (tx_commit),
        .rd_valid    (rd_valid),
        .inv_valid   (inv_valid),
        .ev_valid    (evict_valid),
        .rd_hit      (hit_rd),
        .inv_hit     (hit_inv),
        .ev_hit      (hit_ev),
        .full        (rs_full),
        .active      (tx_active),
        .alloc       (rs_alloc),
        .clear       (rs_clear),
        .abort_pulse (abort_pulse),
        .abort_cause (cause_q),
        .commit_ok   (commit_ok)
    );

    // Present the cause enum on a plain port.
    assign abort_cause = cause_q;

endmodule

// File: rtl/rdset_checker.sv
// Module: rdset_checker
// Temporal properties of the tracker's outputs, attached by bind.
// Assumes: rs_full is the top's internal capacity flag.
module rdset_checker
    import rdset_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tx_begin,
    input logic       tx_active,
    input logic       abort_pulse,
    input logic [1:0] abort_cause,
    input logic       commit_ok,
    input logic       rs_full
);
    AST_BEGIN_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && tx_begin) |=> tx_active); // R2
    AST_ABORT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (abort_cause != 2'b00)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |=> (!abort_pulse && !commit_ok)); // R6
    AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_pulse && abort_cause == 2'b10) |-> $past(rs_full)); // R7
    AST_END_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_pulse || commit_ok) |-> !tx_active); // R8
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort_pulse && commit_ok)); // R9
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse); // R10
    AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_pulse |-> (abort_cause == 2'b00)); // R10
endmodule

bind rdset_abort_tracker rdset_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_begin    (tx_begin),
    .tx_active   (tx_active),
    .abort_pulse (abort_pulse),
    .abort_cause (abort_cause),
    .commit_ok   (commit_ok),
    .rs_full     (rs_full)
);

// File: tb/tb_rdset_abort_tracker.sv
`timescale 1ns/1ps
module tb_rdset_abort_tracker;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tx_begin = 1'b0, tx_commit = 1'b0;
    logic              rd_valid = 1'b0, inv_valid = 1'b0, evict_valid = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0, inv_addr = '0, evict_addr = '0;
    logic              tx_active, abort_pulse, commit_ok;
    logic [1:0]        abort_cause;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    rdset_abort_tracker #(.RS_DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_commit(tx_commit),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .inv_valid(inv_valid),
        .inv_addr(inv_addr), .evict_valid(evict_valid), .evict_addr(evict_addr),
        .tx_active(tx_active), .abort_pulse(abort_pulse),
        .abort_cause(abort_cause), .commit_ok(commit_ok)
    );

    typedef struct packed {
        logic       b, c, r;
        logic [7:0] ra;
        logic       i;
        logic [7:0] ia;
        logic       e;
        logic [7:0] ea;
        logic       x_act, x_abt;
        logic [1:0] x_cause;
        logic       x_cmt;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 24;
    // Each row: inputs for one cycle, outputs expected after that edge.
    localparam vec_t VEC [NV] = '{
        '{0,0,0,8'h00,1,8'hA5,0,8'h00, 0,0,2'b00,0, 4'd6 },  // R6 idle inv
        '{0,0,1,8'h11,0,8'h00,0,8'h00, 0,0,2'b00,0, 4'd11},  // R11 idle read
        '{1,0,0,8'h00,0,8'h00,0,8'h00, 1,0,2'b00,0, 4'd2 },  // R2 begin
        '{0,0,1,8'h11,0,8'h00,0,8'h00, 1,0,2'b00,0, 4'd3 },  // R3
        '{0,0,1,8'h22,0,8'h00,0,8'h00, 1,0,2'b00,0, 4'd3 },  // R3
        '{0,0,0,8'h00,1,8'h33,0,8'h00, 1,0,2'b00,0, 4'd6 },  // R6 miss inv
        '{0,0,0,8'h00,0,8'h00,1,8'h44, 1,0,2'b00,0, 4'd6 },  // R6 miss evict
        '{1,0,0,8'h00,0,8'h00,0,8'h00, 1,0,2'b00,0, 4'd2 },  // R2 begin while open
        '{0,0,0,8'h00,1,8'h22,0,8'h00, 0,1,2'b01,0, 4'd4 },  // R4 conflict
        '{0,0,0,8'h00,0,8'h00,0,8'h00, 0,0,2'b00,0, 4'd10},  // R10 pulse ends
        '{1,0,0,8'h00,0,8'h00,0,8'h00, 1,0,2'b00,0, 4'd2 },  // R2
        '{0,0,0,8'h00,1,8'h22,0,8'h00, 1,0,2'b00,0, 4'd10},  // R10 cleared
        '{0,0,1,8'h55,0,8'h00,0,8'h00, 1,0,2'b00,0, 4'd3 },  // R3
        '{0,0,0,8'h00,0,8'h00,1,8'h55, 0,1,2'b01,0, 4'd5 },  // R5 evict
        '{1,0,0,8'h00,0,8'h00,0,8'h00, 1,0,2'b00,0, 4'd2 },  // R2
        '{0,0,1,8'h66,0,8'h00,0,8'h00, 1,0,2'b00,0, 4'd3 },  // R3
        '{0,1,0,8'h00,0,8'h00,0,8'h00, 0,0,2'b00,1, 4'd8 },  // R8 commit
        '{1,0,0,8'h00,0,8'h00,0,8'h00, 1,0,2'b00,0, 4'd2 },  // R2
        '{0,0,0,8'h00,1,8'h66,0,8'h00, 1,0,2'b00,0, 4'd8 },  // R8 cleared
        '{0,0,1,8'h77,0,8'h00,0,8'h00, 1,0,2'b00,0, 4'd3 },  // R3
        '{0,1,0,8'h00,1,8'h77,0,8'h00, 0,1,2'b01,0, 4'd9 },  // R9 commit+inv
        '{1,0,1,8'h11,0,8'h00,0,8'h00, 1,0,2'b00,0, 4'd11},  // R11 begin-cycle read
        '{0,0,0,8'h00,1,8'h11,0,8'h00, 1,0,2'b00,0, 4'd11},  // R11 not recorded
        '{0,1,0,8'h00,0,8'h00,0,8'h00, 0,0,2'b00,1, 4'd8 }   // R8
    };

    // Compare outputs against expectations and count the result.
    task automatic check(input logic xa, input logic xb, input logic [1:0] xc,
                         input logic xm, input string req);
        checks++;
        if (tx_active !== xa || abort_pulse !== xb || abort_cause !== xc || commit_ok !== xm) begin
            failures++;
            $display("FAIL %s: act/abt/cause/cmt got %b/%b/%b/%b exp %b/%b/%b/%b",
                     req, tx_active, abort_pulse, abort_cause, commit_ok, xa, xb, xc, xm);
        end
    endtask

    // Drive one cycle of inputs from a negedge, return at the next negedge.
    task automatic cyc(input logic b, input logic c, input logic r, input logic [ADDR_W-1:0] ra,
                       input logic i, input logic [ADDR_W-1:0] ia,
                       input logic e, input logic [ADDR_W-1:0] ea);
        tx_begin = b; tx_commit = c; rd_valid = r; rd_addr = ra;
        inv_valid = i; inv_addr = ia; evict_valid = e; evict_addr = ea;
        @(negedge clk);
        tx_begin = 0; tx_commit = 0; rd_valid = 0; inv_valid = 0; evict_valid = 0;
    endtask

    // Open a transaction and read DEPTH distinct lines base+k.
    task automatic fill(input logic [ADDR_W-1:0] base);
        cyc(1, 0, 0, '0, 0, '0, 0, '0);
        for (int k = 0; k < DEPTH; k++)
            cyc(0, 0, 1, base + ADDR_W'(k), 0, '0, 0, '0);
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(0, 0, 2'b00, 0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(0, 0, 2'b00, 0, "R1 after reset");

        // Table walk.
        for (int n = 0; n < NV; n++) begin
            cyc(VEC[n].b, VEC[n].c, VEC[n].r, ADDR_W'(VEC[n].ra), VEC[n].i,
                ADDR_W'(VEC[n].ia), VEC[n].e, ADDR_W'(VEC[n].ea));
            check(VEC[n].x_act, VEC[n].x_abt, VEC[n].x_cause, VEC[n].x_cmt,
                  $sformatf("R%0d vec %0d", VEC[n].req, n));
        end

        // R3: exactly DEPTH lines with interleaved duplicates, no abort.
        cyc(1, 0, 0, '0, 0, '0, 0, '0);
        for (int k = 0; k < DEPTH; k++) begin
            cyc(0, 0, 1, 32'h100 + ADDR_W'(k), 0, '0, 0, '0);
            cyc(0, 0, 1, 32'h100, 0, '0, 0, '0);
        end
        check(1, 0, 2'b00, 0, "R3 full with duplicates");
        cyc(0, 0, 1, 32'h10F, 0, '0, 0, '0);
        check(1, 0, 2'b00, 0, "R3 duplicate at capacity");
        // R7: one more new line overflows.
        cyc(0, 0, 1, 32'h200, 0, '0, 0, '0);
        check(0, 1, 2'b10, 0, "R7 overflow");
        @(negedge clk);
        check(0, 0, 2'b00, 0, "R10 after overflow");

        // R4: conflict on the last slot filled.
        fill(32'h300);
        cyc(0, 0, 0, '0, 1, 32'h300 + ADDR_W'(DEPTH - 1), 0, '0);
        check(0, 1, 2'b01, 0, "R4 last slot");

        // R9: conflict beats overflow on the same cycle.
        fill(32'h400);
        cyc(0, 0, 1, 32'h500, 0, '0, 1, 32'h400);
        check(0, 1, 2'b01, 0, "R9 conflict over overflow");

        // R1: reset during an open transaction.
        cyc(1, 0, 0, '0, 0, '0, 0, '0);
        check(1, 0, 2'b00, 0, "R2 open before reset");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(0, 0, 2'b00, 0, "R1 reset mid transaction");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule